// File: doc/BRIEF.md
# Clock and Reset Controller Register Block

This block is the software-visible register file of a clock and reset controller. It holds nine 32-bit words: one oscillator setup word, the setup words of three PLLs (core, DDR, Ethernet), a core clock source select, a per-device reset word and a clock mux status word. The block sits behind a plain 32-bit register bus with a byte address, a write strobe, a read strobe, write data, registered read data and an error flag that marks accesses to offsets that hold no register.

No oscillator or PLL exists behind these words. The block makes software always see a running oscillator and locked PLLs that use internal feedback. The oscillator ready bit, and the lock and feedback-select bits of the three primary PLL words, are forced to one at reset and again on every write, whatever value software writes. All other words store exactly what is written.

Register offsets (byte address within a 4 KiB window): 0x00 oscillator setup, 0x04 core PLL word A, 0x0C DDR PLL word A, 0x10 DDR PLL word B, 0x1C Ethernet PLL word A, 0x20 Ethernet PLL word B, 0x24 core clock select, 0x28 device resets, 0x2C clock mux status. Every other address, including any address that is not a multiple of four, is unmapped.

Top module: `clkrst_csr`

## Requirements
- R1: After reset, the oscillator setup word reads 0xC000_0000 (ready bit 31 and enable bit 30 set). Each PLL word A (offsets 0x04, 0x0C, 0x1C) reads 0x8201_87C1: divider R field [5:0] = 1, feedback multiplier field [14:6] = 31, output divider field [17:15] = 3, feedback-select bit 25 and lock bit 31 set. The core clock select (offset 0x24) reads 0x0000_0001, bit 0 = 1 selecting the reference clock.
- R2: After reset, both PLL words B (0x10, 0x20), the device reset word (0x28) and the clock mux status word (0x2C) read zero.
- R3: A write to offset 0x00 stores the written value with bit 31 forced to one; all other bits are kept as written.
- R4: A write to offset 0x04, 0x0C or 0x1C stores the written value with bits 31 and 25 forced to one; all other bits are kept as written.
- R5: A write to offset 0x10, 0x20, 0x24, 0x28 or 0x2C stores the written value exactly, with no bit forced.
- R6: Read data is registered: a read strobe in cycle N puts the addressed word on the read data output in cycle N+1. In a cycle that follows a cycle without read strobe, the read data output is zero.
- R7: A read from an unmapped address (including a misaligned one) returns zero and raises the error flag in the following cycle.
- R8: A write to an unmapped address changes no register and raises the error flag in the following cycle.
- R9: A write takes effect on the clock edge where the write strobe is high; a read of the same address in that same cycle returns the value held before the write.
- R10: The error flag is low in the cycle after a cycle in which no strobe is active or every active strobe hit a mapped address, and it is low with read data zero while reset is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (12) | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| err | output | 1 | Unmapped access flag, one cycle after the strobe |

## Verification
Every result of this block is due exactly one cycle after its strobe: the read word and the error flag appear in the cycle after the strobe, and a written word becomes visible to a read issued in the cycle after the write. The bench's reference model takes the bus inputs at each rising edge, computes the response due at the next cycle from its own copy of the register contents and only then applies any write, so a same-cycle read sees the old value. Outputs are compared at the following falling edge, midway through the cycle in which the response is due, on every clock including the reset cycles.

// File: rtl/clkrst_pkg.sv
`timescale 1ns/1ps
package clkrst_pkg;

    localparam int DATA_W = 32;
    localparam int NREG   = 9;
    localparam int OFF_W  = 12;

    typedef enum logic [3:0] {
        RG_OSC, RG_CPLL_A, RG_DPLL_A, RG_DPLL_B, RG_EPLL_A,
        RG_EPLL_B, RG_CKSEL, RG_DEVRST, RG_MUXST
    } reg_id_e;

    localparam int OSC_RDY_BIT  = 31;
    localparam int OSC_EN_BIT   = 30;
    localparam int PLL_LOCK_BIT = 31;
    localparam int PLL_FB_BIT   = 25;
    localparam int PLL_R_LSB    = 0;
    localparam int PLL_F_LSB    = 6;
    localparam int PLL_Q_LSB    = 15;
    localparam int PLL_R_DEF    = 1;
    localparam int PLL_F_DEF    = 31;
    localparam int PLL_Q_DEF    = 3;
    localparam int CKSEL_REF    = 1;

    typedef logic [NREG-1:0][DATA_W-1:0] reg_image_t;

    typedef struct packed {
        reg_image_t regs;
    } regfile_st_t;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              err;
    } rsp_st_t;

    function automatic logic [OFF_W-1:0] reg_offset(input int idx);
        case (idx)
            int'(RG_OSC):    return 12'h000;
            int'(RG_CPLL_A): return 12'h004;
            int'(RG_DPLL_A): return 12'h00C;
            int'(RG_DPLL_B): return 12'h010;
            int'(RG_EPLL_A): return 12'h01C;
            int'(RG_EPLL_B): return 12'h020;
            int'(RG_CKSEL):  return 12'h024;
            int'(RG_DEVRST): return 12'h028;
            default:         return 12'h02C;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] osc_force();
        return DATA_W'(1) << OSC_RDY_BIT;
    endfunction

    function automatic logic [DATA_W-1:0] pll_force();
        return (DATA_W'(1) << PLL_LOCK_BIT) | (DATA_W'(1) << PLL_FB_BIT);
    endfunction

    function automatic logic is_pll_a(input int idx);
        return idx == int'(RG_CPLL_A) || idx == int'(RG_DPLL_A) ||
               idx == int'(RG_EPLL_A);
    endfunction

    function automatic logic [DATA_W-1:0] reg_force(input int idx);
        if (idx == int'(RG_OSC)) return osc_force();
        if (is_pll_a(idx))       return pll_force();
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        if (idx == int'(RG_OSC))
            return osc_force() | (DATA_W'(1) << OSC_EN_BIT);
        if (is_pll_a(idx))
            return pll_force()
                 | (DATA_W'(PLL_R_DEF) << PLL_R_LSB)
                 | (DATA_W'(PLL_F_DEF) << PLL_F_LSB)
                 | (DATA_W'(PLL_Q_DEF) << PLL_Q_LSB);
        if (idx == int'(RG_CKSEL))
            return DATA_W'(CKSEL_REF);
        return '0;
    endfunction

    function automatic reg_image_t reset_image();
        reg_image_t img;
        for (int i = 0; i < NREG; i++) img[i] = reg_reset(i);
        return img;
    endfunction

endpackage

// File: rtl/clkrst_decode.sv
`timescale 1ns/1ps
module clkrst_decode
    import clkrst_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel,
    output logic              hit
);

    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign sel[g] = (addr == ADDR_W'(reg_offset(g)));
    end

    assign hit = |sel;

endmodule

// File: rtl/clkrst_regfile.sv
`timescale 1ns/1ps
module clkrst_regfile
    import clkrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NREG-1:0]   sel,
    input  logic [DATA_W-1:0] wr_data,
    output reg_image_t        regs_q
);

    localparam reg_image_t RESET_IMG = reset_image();

    regfile_st_t st_d;
    regfile_st_t st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && sel[i]) begin
                st_d.regs[i] = wr_data | reg_force(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= RESET_IMG;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_q = st_q.regs;

endmodule

// File: rtl/clkrst_rdmux.sv
`timescale 1ns/1ps
module clkrst_rdmux
    import clkrst_pkg::*;
(
    input  logic [NREG-1:0]   sel,
    input  reg_image_t        regs,
    output logic [DATA_W-1:0] data
);

    reg_image_t masked;

    for (genvar g = 0; g < NREG; g++) begin : g_mask
        assign masked[g] = sel[g] ? regs[g] : '0;
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            data = data | masked[i];
        end
    end

endmodule

// File: rtl/clkrst_csr.sv
`timescale 1ns/1ps
module clkrst_csr
    import clkrst_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              err
);

    logic [NREG-1:0]   acc_sel;
    logic              acc_hit;
    reg_image_t        regs_q;
    logic [DATA_W-1:0] mux_data;

    rsp_st_t rsp_d;
    rsp_st_t rsp_q;

    clkrst_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (acc_sel),
        .hit  (acc_hit)
    );

    clkrst_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (acc_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    clkrst_rdmux u_rdmux (
        .sel  (acc_sel),
        .regs (regs_q),
        .data (mux_data)
    );

    always_comb begin
        rsp_d         = rsp_q;
        rsp_d.rd_data = rd_en ? mux_data : '0;
        rsp_d.err     = (rd_en || wr_en) && !acc_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_data = rsp_q.rd_data;
    assign err     = rsp_q.err;

endmodule

// File: rtl/clkrst_csr_chk.sv
`timescale 1ns/1ps
module clkrst_csr_chk
    import clkrst_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              err,
    input logic              acc_hit,
    input reg_image_t        regs
);

    localparam logic [ADDR_W-1:0] A_OSC  = ADDR_W'(reg_offset(int'(RG_OSC)));
    localparam logic [ADDR_W-1:0] A_CPLL = ADDR_W'(reg_offset(int'(RG_CPLL_A)));
    localparam logic [ADDR_W-1:0] A_DPLL = ADDR_W'(reg_offset(int'(RG_DPLL_A)));
    localparam logic [ADDR_W-1:0] A_EPLL = ADDR_W'(reg_offset(int'(RG_EPLL_A)));

    a_r3_osc_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_OSC) |=> rd_data[OSC_RDY_BIT]);

    a_r4_pll_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_CPLL || addr == A_DPLL || addr == A_EPLL))
        |=> (rd_data[PLL_LOCK_BIT] && rd_data[PLL_FB_BIT]));

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    a_r7_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !acc_hit) |=> (rd_data == '0 && err));

    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_hit) |=> ($stable(regs) && err));

    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en || wr_en) || acc_hit) |=> !err);

endmodule

bind clkrst_csr clkrst_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .err     (err),
    .acc_hit (acc_hit),
    .regs    (regs_q)
);

// File: tb/tb_clkrst_csr.sv
`timescale 1ns/1ps
module tb_clkrst_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        err;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R10";
    string exp_tag = "R10";
    logic [31:0] exp_rd = '0;
    logic        exp_err = 1'b0;
    logic [31:0] mdl [int];

    always #2.5 clk = ~clk;

    clkrst_csr dut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data), .err (err)
    );

    task automatic model_reset();
        mdl.delete();
        mdl[32'h00] = 32'hC000_0000;
        mdl[32'h04] = 32'h8201_87C1;
        mdl[32'h0C] = 32'h8201_87C1;
        mdl[32'h10] = 32'h0;
        mdl[32'h1C] = 32'h8201_87C1;
        mdl[32'h20] = 32'h0;
        mdl[32'h24] = 32'h1;
        mdl[32'h28] = 32'h0;
        mdl[32'h2C] = 32'h0;
    endtask

    function automatic logic [31:0] forced(input int a, input logic [31:0] v);
        if (a == 32'h00) return v | 32'h8000_0000;
        if (a == 32'h04 || a == 32'h0C || a == 32'h1C) return v | 32'h8200_0000;
        return v;
    endfunction

    // reference model: response due one cycle after the edge, then write
    always @(posedge clk) begin
        int  a;
        logic mapped;
        a = int'(addr);
        if (!rst_n) begin
            model_reset();
            exp_rd  = '0;
            exp_err = 1'b0;
        end else begin
            mapped  = mdl.exists(a);
            exp_rd  = (rd_en && mapped) ? mdl[a] : 32'h0;
            exp_err = (rd_en || wr_en) && !mapped;
            if (wr_en && mapped) mdl[a] = forced(a, wr_data);
        end
        exp_tag = cur_tag;
    end

    always @(negedge clk) begin
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data: actual %h expected %h", exp_tag, rd_data, exp_rd);
        end
        checks++;
        if (err !== exp_err) begin
            errors++;
            $display("FAIL %s err: actual %b expected %b", exp_tag, err, exp_err);
        end
    end

    task automatic bus(input logic w, input logic r, input logic [11:0] a,
                       input logic [31:0] d, input string tag);
        cur_tag = tag;
        wr_en   = w;
        rd_en   = r;
        addr    = a;
        wr_data = d;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        bus(1'b0, 1'b0, 12'h0, 32'h0, tag);
    endtask

    task automatic wr_rd(input logic [11:0] a, input logic [31:0] d, input string tag);
        bus(1'b1, 1'b0, a, d, tag);
        bus(1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic read_all(input string tag);
        bus(1'b0, 1'b1, 12'h00, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h04, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h0C, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h10, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h1C, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h20, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h24, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h28, 32'h0, tag);
        bus(1'b0, 1'b1, 12'h2C, 32'h0, tag);
    endtask

    initial begin
        logic [11:0] pll_a [3];
        logic [11:0] plain [5];
        logic [11:0] holes [8];
        logic [31:0] pats  [4];
        pll_a = '{12'h04, 12'h0C, 12'h1C};
        plain = '{12'h10, 12'h20, 12'h24, 12'h28, 12'h2C};
        holes = '{12'h08, 12'h14, 12'h18, 12'h30, 12'hFFC, 12'h001, 12'h026, 12'h403};
        pats  = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5678};

        // R10: outputs quiet while reset is held
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle("R10");

        // R1 / R2: reset contents
        bus(1'b0, 1'b1, 12'h00, 32'h0, "R1");
        bus(1'b0, 1'b1, 12'h04, 32'h0, "R1");
        bus(1'b0, 1'b1, 12'h0C, 32'h0, "R1");
        bus(1'b0, 1'b1, 12'h1C, 32'h0, "R1");
        bus(1'b0, 1'b1, 12'h24, 32'h0, "R1");
        bus(1'b0, 1'b1, 12'h10, 32'h0, "R2");
        bus(1'b0, 1'b1, 12'h20, 32'h0, "R2");
        bus(1'b0, 1'b1, 12'h28, 32'h0, "R2");
        bus(1'b0, 1'b1, 12'h2C, 32'h0, "R2");

        // R6: no read strobe gives zero read data
        idle("R6");
        idle("R6");

        // R3: oscillator ready bit forced
        for (int p = 0; p < 4; p++) wr_rd(12'h00, pats[p], "R3");

        // R4: lock and feedback-select forced on every PLL word A
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < 4; p++) wr_rd(pll_a[k], pats[p] & 32'h7DFF_FFFF, "R4");

        // R5: plain words store as written
        for (int k = 0; k < 5; k++)
            for (int p = 0; p < 4; p++) wr_rd(plain[k], pats[p] ^ {20'h0, plain[k]}, "R5");

        // R9: same-cycle read sees the old value, next read sees the new one
        bus(1'b1, 1'b1, 12'h28, 32'hDEAD_BEEF, "R9");
        bus(1'b1, 1'b1, 12'h00, 32'h0000_0000, "R9");
        bus(1'b0, 1'b1, 12'h28, 32'h0, "R9");
        bus(1'b0, 1'b1, 12'h00, 32'h0, "R9");

        // R7: unmapped reads
        for (int k = 0; k < 8; k++) bus(1'b0, 1'b1, holes[k], 32'h0, "R7");
        idle("R10");

        // R8: unmapped writes leave every word unchanged
        for (int k = 0; k < 8; k++) bus(1'b1, 1'b0, holes[k], 32'hFFFF_FFFF, "R8");
        read_all("R8");

        // R10: mapped write and read clear the flag
        bus(1'b0, 1'b1, 12'h3C, 32'h0, "R7");
        bus(1'b1, 1'b0, 12'h24, 32'h0, "R10");
        bus(1'b0, 1'b1, 12'h24, 32'h0, "R10");
        idle("R10");

        // reset again mid-run restores defaults (R1, R2)
        cur_tag = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_all("R2");
        idle("R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule